// File: doc/BRIEF.md
# Shared-Counter Six-Channel PWM Timer

This block is a register-programmed pulse-width modulator with six edge-aligned output channels. All six channels use one 16-bit up-counter. That counter runs from zero to a programmable period limit and then wraps. It steps once every 2^PS input clocks, where PS is a 3-bit prescale code. Each channel has its own compare value and configuration field, and it drives one output pin. An output is high-true or low-true according to how the counter compares with the channel's compare value.

Software programs the block through a simple synchronous bus with separate write and read strobes. Changes to the period limit and to the compare values are staged. While the counter runs, a staged value takes effect only at the wrap, so a waveform never changes in the middle of a period. While the counter is stopped, a staged value takes effect at once. Each channel also has a sticky match flag. Software clears it by writing a one to it.

Top module: `pwm_shared_timer`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0, the counter is stopped and all six outputs are low.
- R2: The clock-mode field (control register at 0x00, bits [4:3]) lets the counter step only when it holds 01. Every other code freezes the counter. A read of the counter register (0x04) returns the live count.
- R3: The prescale code PS (control bits [2:0]) makes the counter advance once every 2^PS clocks, so a channel's high time and its period both scale by 2^PS.
- R4: The counter counts 0, 1, ..., P and then returns to 0, where P is the period register (0x08). One output period therefore lasts (P+1)·2^PS clocks.
- R5: A write to the period register reads back at once. It governs counting at once while the counter is stopped. While the counter runs, it takes effect only at the next wrap.
- R6: A channel whose configuration selects PWM mode and high-true level drives its output high while the count is below its compare value C, and low otherwise. C = 0 gives a constantly low output, and C > P gives a constantly high output.
- R7: A PWM-mode channel with low-true level drives the complement of the R6 waveform.
- R8: A channel output stays low unless its mode bits are exactly mode-B=1 and mode-A=0 and at least one level bit is set.
- R9: A write to a channel's compare register (0x14 + 8·n) reads back at once. It is applied at the wrap while the counter runs, and at once while it is stopped.
- R10: The channel register (0x10 + 8·n) holds flag bit 7, mode-B bit 5, mode-A bit 4, high-true level bit 3 and low-true level bit 2. The flag sets on any counter step taken while the count equals the channel's compare value, whatever the output mode. Writing 1 to bit 7 clears it, writing 0 leaves it, and a new match wins over a clear.
- R11: Read data appears one cycle after the read strobe and is 0 in every other cycle. Unmapped addresses and unused bits (including control bit 5, the centre-aligned select, which stays 0) read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_rd | input | 1 | Read strobe; data follows one cycle later |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data, zero when no read is pending |
| pwm_out | output | 6 | One PWM output per channel |

## Verification
The bench runs a behavioural model that advances with the design on every clock and compares `pwm_out` and `bus_rdata` at each falling edge. Each output pin is due one cycle after the count and active compare value that produce it. The active compare and period values change on the edge that takes a staged write, or on the wrap edge. Read data is due on the edge after the strobe cycle, so the model returns it one step late. Directed checks add independent figures. These are pulse periods and high times measured from the pin edges over whole periods, read-back values fetched two bench steps after each strobe, and counter deltas between reads spaced a known number of cycles apart.

// File: rtl/pwmt_pkg.sv
// Shared types and register layout for the shared-counter PWM timer.
// Assumes byte addressing with 32-bit aligned registers.
package pwmt_pkg;

    // Counter clock-mode codes; only CM_RUN advances the counter.
    typedef enum logic [1:0] {
        CM_STOP  = 2'b00,
        CM_RUN   = 2'b01,
        CM_RSV_A = 2'b10,
        CM_RSV_B = 2'b11
    } clk_mode_e;

    // Per-channel configuration field (bits 5..2 of the channel register).
    typedef struct packed {
        logic mode_b;   // PWM select, must be 1
        logic mode_a;   // must be 0 for PWM
        logic lvl_hi;   // high-true pulse
        logic lvl_lo;   // low-true pulse
    } ch_cfg_t;

    localparam int CFG_W       = $bits(ch_cfg_t);
    localparam int CFG_LSB     = 2;
    localparam int FLAG_BIT    = 7;

    localparam int OFS_CTRL    = 0;
    localparam int OFS_COUNT   = 4;
    localparam int OFS_PERIOD  = 8;
    localparam int OFS_CH_BASE = 16;
    localparam int CH_STRIDE   = 8;
    localparam int CH_CMP_OFS  = 4;

    // True when the configuration lets the channel drive its pin.
    function automatic logic cfg_drives(ch_cfg_t c);
        return c.mode_b & ~c.mode_a & (c.lvl_hi | c.lvl_lo);
    endfunction

    // True when the pulse is low-true (high-true takes priority).
    function automatic logic cfg_inverted(ch_cfg_t c);
        return ~c.lvl_hi;
    endfunction

endpackage

// File: rtl/pwmt_timebase.sv
// Shared time base: power-of-two prescaler, up-counter with modulo wrap,
// and the staged period register. Assumes PS_W is small (divide <= 2^(2^PS_W-1)).
module pwmt_timebase
    import pwmt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PS_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  clk_mode_e        mode_i,
    input  logic [PS_W-1:0]  ps_i,
    input  logic             per_wr_i,
    input  logic [CNT_W-1:0] per_wdata_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] per_pend_o,
    output logic             run_o,
    output logic             tick_o,
    output logic             wrap_o
);

    localparam int PRE_W = (1 << PS_W) - 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] pre_lim;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] per_pend_q;
    logic [CNT_W-1:0] per_act_q;

    assign run_o   = (mode_i == CM_RUN);
    assign pre_lim = (PRE_W'(1) << ps_i) - PRE_W'(1);
    assign tick_o  = run_o && (pre_q >= pre_lim);
    assign wrap_o  = tick_o && (cnt_q >= per_act_q);
    assign cnt_o      = cnt_q;
    assign per_pend_o = per_pend_q;

    // Prescaler: counts input clocks between counter steps, idle when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)                pre_q <= '0;
        else if (!run_o || tick_o) pre_q <= '0;
        else                       pre_q <= pre_q + PRE_W'(1);
    end

    // Main counter: steps on each prescaled tick and wraps past the period.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (tick_o) cnt_q <= wrap_o ? '0 : cnt_q + CNT_W'(1);
    end

    // Staged period value, always the last written one.
    always_ff @(posedge clk) begin
        if (!rst_n)        per_pend_q <= '0;
        else if (per_wr_i) per_pend_q <= per_wdata_i;
    end

    // Active period: follows writes at once when stopped, else loads at wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)      per_act_q <= '0;
        else if (!run_o) per_act_q <= per_wr_i ? per_wdata_i : per_pend_q;
        else if (wrap_o) per_act_q <= per_pend_q;
    end

    assert_hold_when_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run_o |=> cnt_q == $past(cnt_q));

    assert_wrap_to_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> cnt_q == '0);

    assert_count_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && cnt_q <= per_act_q) |=> cnt_q <= per_act_q);

    assert_period_staged_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && !wrap_o) |=> $stable(per_act_q));

endmodule

// File: rtl/pwmt_channel.sv
// One PWM channel: configuration field, staged compare value, sticky match
// flag and a registered output pin. Assumes the time-base strobes are
// generated in the same clock domain.
module pwmt_channel
    import pwmt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic             wrap_i,
    input  logic             cfg_wr_i,
    input  ch_cfg_t          cfg_wdata_i,
    input  logic             flag_clr_i,
    input  logic             cmp_wr_i,
    input  logic [CNT_W-1:0] cmp_wdata_i,
    output ch_cfg_t          cfg_o,
    output logic             flag_o,
    output logic [CNT_W-1:0] cmp_pend_o,
    output logic             pwm_o
);

    ch_cfg_t          cfg_q;
    logic             flag_q;
    logic [CNT_W-1:0] cmp_pend_q;
    logic [CNT_W-1:0] cmp_act_q;
    logic             pwm_q;
    logic             match;
    logic             below;

    assign match      = tick_i && (cnt_i == cmp_act_q);
    assign below      = cnt_i < cmp_act_q;
    assign cfg_o      = cfg_q;
    assign flag_o     = flag_q;
    assign cmp_pend_o = cmp_pend_q;
    assign pwm_o      = pwm_q;

    // Configuration field, written directly.
    always_ff @(posedge clk) begin
        if (!rst_n)        cfg_q <= '0;
        else if (cfg_wr_i) cfg_q <= cfg_wdata_i;
    end

    // Sticky match flag; a new match beats a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= match | (flag_q & ~flag_clr_i);
    end

    // Staged compare value, always the last written one.
    always_ff @(posedge clk) begin
        if (!rst_n)        cmp_pend_q <= '0;
        else if (cmp_wr_i) cmp_pend_q <= cmp_wdata_i;
    end

    // Active compare: immediate while stopped, loaded at wrap while running.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmp_act_q <= '0;
        else if (!run_i) cmp_act_q <= cmp_wr_i ? cmp_wdata_i : cmp_pend_q;
        else if (wrap_i) cmp_act_q <= cmp_pend_q;
    end

    // Output pin: registered compare result with polarity and enable.
    always_ff @(posedge clk) begin
        if (!rst_n)                 pwm_q <= 1'b0;
        else if (!cfg_drives(cfg_q)) pwm_q <= 1'b0;
        else                        pwm_q <= cfg_inverted(cfg_q) ? ~below : below;
    end

    assert_off_when_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_drives(cfg_q) |=> !pwm_q);

    assert_flag_sets_on_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> flag_q);

    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !flag_clr_i) |=> flag_q);

    assert_compare_staged_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !wrap_i) |=> $stable(cmp_act_q));

endmodule

// File: rtl/pwmt_busdec.sv
// Register bus front end: decodes write strobes for each register and
// returns registered read data one cycle after a read strobe.
// Assumes every register sits on a 4-byte aligned address below 2^ADDR_W.
module pwmt_busdec
    import pwmt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int CH_N   = 6,
    parameter int PS_W   = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_i,
    input  logic                         rd_i,
    input  logic [ADDR_W-1:0]            addr_i,
    input  clk_mode_e                    mode_i,
    input  logic [PS_W-1:0]              ps_i,
    input  logic [DATA_W-1:0]            cnt_i,
    input  logic [DATA_W-1:0]            per_pend_i,
    input  ch_cfg_t [CH_N-1:0]           cfg_i,
    input  logic [CH_N-1:0]              flag_i,
    input  logic [CH_N-1:0][DATA_W-1:0]  cmp_i,
    output logic                         ctrl_wr_o,
    output logic                         per_wr_o,
    output logic [CH_N-1:0]              cfg_wr_o,
    output logic [CH_N-1:0]              cmp_wr_o,
    output logic [DATA_W-1:0]            rdata_o
);

    logic [DATA_W-1:0] rd_val;
    logic [DATA_W-1:0] rdata_q;

    assign ctrl_wr_o = wr_i && (addr_i == ADDR_W'(OFS_CTRL));
    assign per_wr_o  = wr_i && (addr_i == ADDR_W'(OFS_PERIOD));
    assign rdata_o   = rdata_q;

    // Per-channel write strobes, one pair per channel.
    for (genvar g = 0; g < CH_N; g++) begin : g_ch_dec
        assign cfg_wr_o[g] = wr_i && (addr_i == ADDR_W'(OFS_CH_BASE + g * CH_STRIDE));
        assign cmp_wr_o[g] = wr_i && (addr_i == ADDR_W'(OFS_CH_BASE + g * CH_STRIDE + CH_CMP_OFS));
    end

    // Read multiplexer over all mapped registers; unmapped reads give 0.
    always_comb begin
        rd_val = '0;
        if (addr_i == ADDR_W'(OFS_CTRL)) begin
            rd_val[PS_W-1:0]  = ps_i;
            rd_val[PS_W +: 2] = mode_i;
        end
        if (addr_i == ADDR_W'(OFS_COUNT))  rd_val = cnt_i;
        if (addr_i == ADDR_W'(OFS_PERIOD)) rd_val = per_pend_i;
        for (int i = 0; i < CH_N; i++) begin
            if (addr_i == ADDR_W'(OFS_CH_BASE + i * CH_STRIDE)) begin
                rd_val[FLAG_BIT]         = flag_i[i];
                rd_val[CFG_LSB +: CFG_W] = cfg_i[i];
            end
            if (addr_i == ADDR_W'(OFS_CH_BASE + i * CH_STRIDE + CH_CMP_OFS))
                rd_val = cmp_i[i];
        end
    end

    // Read data register: captures on a read strobe, otherwise returns to 0.
    always_ff @(posedge clk) begin
        if (!rst_n)    rdata_q <= '0;
        else if (rd_i) rdata_q <= rd_val;
        else           rdata_q <= '0;
    end

    assert_rdata_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> rdata_q == '0);

    assert_single_write_target_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctrl_wr_o, per_wr_o, cfg_wr_o, cmp_wr_o}));

endmodule

// File: rtl/pwm_shared_timer.sv
// Top level: six PWM channels sharing one time base, behind a simple
// synchronous register bus. Assumes a single clock and synchronous reset.
module pwm_shared_timer
    import pwmt_pkg::*;
#(
    parameter int CH_N   = 6,
    parameter int CNT_W  = 16,
    parameter int PS_W   = 3,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic [CH_N-1:0]   pwm_out
);

    clk_mode_e                  mode_q;
    logic [PS_W-1:0]            ps_q;
    logic                       ctrl_wr;
    logic                       per_wr;
    logic [CH_N-1:0]            cfg_wr;
    logic [CH_N-1:0]            cmp_wr;
    logic [CNT_W-1:0]           cnt;
    logic [CNT_W-1:0]           per_pend;
    logic                       run;
    logic                       tick;
    logic                       wrap;
    ch_cfg_t [CH_N-1:0]         cfg;
    logic [CH_N-1:0]            flag;
    logic [CH_N-1:0][CNT_W-1:0] cmp;

    // Control register: clock mode and prescale code (centre bit not stored).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= CM_STOP;
            ps_q   <= '0;
        end else if (ctrl_wr) begin
            mode_q <= clk_mode_e'(bus_wdata[PS_W +: 2]);
            ps_q   <= bus_wdata[PS_W-1:0];
        end
    end

    pwmt_busdec #(
        .ADDR_W (ADDR_W),
        .DATA_W (CNT_W),
        .CH_N   (CH_N),
        .PS_W   (PS_W)
    ) u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (bus_wr),
        .rd_i       (bus_rd),
        .addr_i     (bus_addr),
        .mode_i     (mode_q),
        .ps_i       (ps_q),
        .cnt_i      (cnt),
        .per_pend_i (per_pend),
        .cfg_i      (cfg),
        .flag_i     (flag),
        .cmp_i      (cmp),
        .ctrl_wr_o  (ctrl_wr),
        .per_wr_o   (per_wr),
        .cfg_wr_o   (cfg_wr),
        .cmp_wr_o   (cmp_wr),
        .rdata_o    (bus_rdata)
    );

    pwmt_timebase #(
        .CNT_W (CNT_W),
        .PS_W  (PS_W)
    ) u_tb (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode_q),
        .ps_i        (ps_q),
        .per_wr_i    (per_wr),
        .per_wdata_i (bus_wdata),
        .cnt_o       (cnt),
        .per_pend_o  (per_pend),
        .run_o       (run),
        .tick_o      (tick),
        .wrap_o      (wrap)
    );

    for (genvar g = 0; g < CH_N; g++) begin : g_ch
        pwmt_channel #(
            .CNT_W (CNT_W)
        ) u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .cnt_i       (cnt),
            .run_i       (run),
            .tick_i      (tick),
            .wrap_i      (wrap),
            .cfg_wr_i    (cfg_wr[g]),
            .cfg_wdata_i (ch_cfg_t'(bus_wdata[CFG_LSB +: CFG_W])),
            .flag_clr_i  (cfg_wr[g] & bus_wdata[FLAG_BIT]),
            .cmp_wr_i    (cmp_wr[g]),
            .cmp_wdata_i (bus_wdata),
            .cfg_o       (cfg[g]),
            .flag_o      (flag[g]),
            .cmp_pend_o  (cmp[g]),
            .pwm_o       (pwm_out[g])
        );
    end

endmodule

// File: tb/sim_pwm_shared_timer.sv
`timescale 1ns/1ps
module sim_pwm_shared_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [5:0]  pwm_out;

    always #4 clk = ~clk;

    pwm_shared_timer u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    int    n_tests = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    bit    armed = 1'b0;
    string cur_req = "R1";

    // Behavioural reference state.
    int m_mode, m_ps, m_pre, m_cnt, m_per_p, m_per_a, m_rdata;
    int m_cfg[6], m_flag[6], m_cvp[6], m_cva[6], m_out[6];

    // Pin measurements.
    int cyc = 0, seen_rdata = 0;
    int last_rise[6], per_meas[6], hi_acc[6], hi_last[6], ever_hi[6], prev_out[6];

    task automatic chk(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    function automatic int mdl_read(int a);
        if (a == 0) return (m_mode << 3) | m_ps;
        if (a == 4) return m_cnt;
        if (a == 8) return m_per_p;
        for (int i = 0; i < 6; i++) begin
            if (a == 16 + 8 * i) return (m_flag[i] << 7) | (m_cfg[i] << 2);
            if (a == 20 + 8 * i) return m_cvp[i];
        end
        return 0;
    endfunction

    function automatic int mdl_pin(int i);
        bit drives, below;
        drives = m_cfg[i][3] && !m_cfg[i][2] && (m_cfg[i][1] || m_cfg[i][0]);
        below  = m_cnt < m_cva[i];
        if (!drives) return 0;
        return m_cfg[i][1] ? int'(below) : int'(!below);
    endfunction

    task automatic model_step(bit r, bit w, bit rdv, int a, int d);
        bit run, tick, wrap;
        int lim;
        int n_rd;
        int n_pin[6];
        int hit[6];
        if (!r) begin
            m_mode = 0; m_ps = 0; m_pre = 0; m_cnt = 0; m_per_p = 0; m_per_a = 0; m_rdata = 0;
            for (int i = 0; i < 6; i++) begin
                m_cfg[i] = 0; m_flag[i] = 0; m_cvp[i] = 0; m_cva[i] = 0; m_out[i] = 0;
            end
            return;
        end
        run  = (m_mode == 1);
        lim  = (1 << m_ps) - 1;
        tick = run && (m_pre >= lim);
        wrap = tick && (m_cnt >= m_per_a);
        n_rd = rdv ? mdl_read(a) : 0;
        for (int i = 0; i < 6; i++) begin
            n_pin[i] = mdl_pin(i);
            hit[i]   = (tick && m_cnt == m_cva[i]) ? 1 : 0;
        end
        for (int i = 0; i < 6; i++) begin
            bit wcfg, wcmp;
            wcfg = w && (a == 16 + 8 * i);
            wcmp = w && (a == 20 + 8 * i);
            m_flag[i] = (hit[i] != 0 || (m_flag[i] != 0 && !(wcfg && d[7]))) ? 1 : 0;
            if (!run)      m_cva[i] = wcmp ? d : m_cvp[i];
            else if (wrap) m_cva[i] = m_cvp[i];
            if (wcmp) m_cvp[i] = d;
            if (wcfg) m_cfg[i] = (d >> 2) & 15;
            m_out[i] = n_pin[i];
        end
        if (!run)      m_per_a = (w && a == 8) ? d : m_per_p;
        else if (wrap) m_per_a = m_per_p;
        if (w && a == 8) m_per_p = d;
        if (!run || tick) m_pre = 0; else m_pre = m_pre + 1;
        if (tick) m_cnt = wrap ? 0 : ((m_cnt + 1) & 16'hFFFF);
        if (w && a == 0) begin
            m_mode = (d >> 3) & 3;
            m_ps   = d & 7;
        end
        m_rdata = n_rd;
    endtask

    // Compare the pins and read data with the model; update pin measurements.
    task automatic compare();
        int pins;
        pins = 0;
        for (int i = 0; i < 6; i++) pins |= m_out[i] << i;
        chk({cur_req, " pwm_out"}, int'(pwm_out), pins);
        chk({cur_req, " bus_rdata"}, int'(bus_rdata), m_rdata);
        seen_rdata = int'(bus_rdata);
        for (int i = 0; i < 6; i++) begin
            if (pwm_out[i] && prev_out[i] == 0) begin
                per_meas[i]  = cyc - last_rise[i];
                last_rise[i] = cyc;
                hi_last[i]   = hi_acc[i];
                hi_acc[i]    = 0;
            end
            if (pwm_out[i]) begin
                hi_acc[i]++;
                ever_hi[i] = 1;
            end
            prev_out[i] = int'(pwm_out[i]);
        end
        cyc++;
    endtask

    task automatic cycle(bit r, bit w, bit rdv, int a, int d);
        @(negedge clk);
        if (armed) compare();
        rst_n     = r;
        bus_wr    = w;
        bus_rd    = rdv;
        bus_addr  = a[7:0];
        bus_wdata = d[15:0];
        model_step(r, w, rdv, a, d);
        armed = 1'b1;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) cycle(1, 0, 0, 0, 0);
    endtask

    task automatic wr_reg(int a, int d);
        cycle(1, 1, 0, a, d);
    endtask

    task automatic rd_reg(int a, output int v);
        cycle(1, 0, 1, a, 0);
        cycle(1, 0, 0, 0, 0);
        v = seen_rdata;
    endtask

    task automatic clear_meas();
        for (int i = 0; i < 6; i++) begin
            last_rise[i] = cyc; per_meas[i] = 0; hi_acc[i] = 0;
            hi_last[i] = 0; ever_hi[i] = 0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired before the sequence finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int v, v2;
        for (int i = 0; i < 6; i++) prev_out[i] = 0;
        clear_meas();

        // R1: reset state
        cur_req = "R1";
        for (int k = 0; k < 4; k++) cycle(0, 0, 0, 0, 0);
        idle(1);
        rd_reg(0, v);    chk("R1 control", v, 0);
        rd_reg(4, v);    chk("R1 count", v, 0);
        rd_reg(8, v);    chk("R1 period", v, 0);
        rd_reg(16, v);   chk("R1 ch0 config", v, 0);
        rd_reg(60, v);   chk("R1 ch5 compare", v, 0);
        chk("R1 pins", int'(pwm_out), 0);

        // R5 stopped write, R11 map details
        cur_req = "R5";
        wr_reg(8, 9);
        rd_reg(8, v);    chk("R5 period readback", v, 9);
        cur_req = "R11";
        wr_reg(0, 16'h0020);
        rd_reg(0, v);    chk("R11 centre bit reads 0", v, 0);
        rd_reg(12, v);   chk("R11 unmapped 0x0C", v, 0);
        rd_reg(64, v);   chk("R11 unmapped 0x40", v, 0);

        // Channel set-up: high-true, low-true, off, wrong mode, 0%, 100%
        cur_req = "R6";
        wr_reg(16, 16'h28); wr_reg(20, 4);
        wr_reg(24, 16'h24); wr_reg(28, 4);
        wr_reg(32, 16'h20); wr_reg(36, 4);
        wr_reg(40, 16'h38); wr_reg(44, 4);
        wr_reg(48, 16'h28); wr_reg(52, 0);
        wr_reg(56, 16'h28); wr_reg(60, 10);
        clear_meas();
        wr_reg(0, 16'h08);
        idle(40);
        chk("R4 period P=9 PS=0", per_meas[0], 10);
        chk("R6 high time C=4", hi_last[0], 4);
        chk("R7 low-true period", per_meas[1], 10);
        chk("R7 low-true high time", hi_last[1], 6);
        chk("R8 both level bits clear", ever_hi[2], 0);
        chk("R8 mode-A set", ever_hi[3], 0);
        chk("R6 C=0 never high", ever_hi[4], 0);
        chk("R6 C>P constant high", int'(pwm_out[5]), 1);

        // R3: prescale by 4
        cur_req = "R3";
        wr_reg(0, 16'h0A);
        idle(5);
        clear_meas();
        idle(130);
        chk("R3 period P=9 PS=2", per_meas[0], 40);
        chk("R3 high time C=4 PS=2", hi_last[0], 16);

        // R5: period change while running
        cur_req = "R5";
        wr_reg(8, 4);
        rd_reg(8, v);    chk("R5 running readback", v, 4);
        idle(60);
        clear_meas();
        idle(100);
        chk("R5 new period P=4 PS=2", per_meas[0], 20);
        chk("R5 high time C=4", hi_last[0], 16);

        // R9: compare change while running, then while stopped
        cur_req = "R9";
        wr_reg(8, 9);
        wr_reg(0, 16'h08);
        wr_reg(20, 7);
        rd_reg(20, v);   chk("R9 compare readback", v, 7);
        idle(30);
        clear_meas();
        idle(40);
        chk("R9 high time C=7", hi_last[0], 7);
        wr_reg(0, 16'h00);
        wr_reg(20, 0);
        idle(2);
        chk("R9 stopped compare at once", int'(pwm_out[0]), 0);

        // R10: match flags (counter stopped, so no new matches)
        cur_req = "R10";
        rd_reg(16, v);   chk("R10 flag set ch0", v, 16'hA8);
        rd_reg(32, v);   chk("R10 flag set on disabled ch2", v, 16'hA0);
        wr_reg(16, 16'h28);
        rd_reg(16, v);   chk("R10 write 0 keeps flag", v, 16'hA8);
        wr_reg(16, 16'hA8);
        rd_reg(16, v);   chk("R10 write 1 clears flag", v, 16'h28);

        // R2: stop / reserved mode hold, run advances
        cur_req = "R2";
        rd_reg(4, v); rd_reg(4, v2);
        chk("R2 stopped counter holds", v2, v);
        wr_reg(0, 16'h18);
        idle(3);
        rd_reg(4, v); rd_reg(4, v2);
        chk("R2 reserved mode holds", v2, v);
        wr_reg(0, 16'h08);
        idle(3);
        rd_reg(4, v); rd_reg(4, v2);
        chk("R2 live count advances by 2", (v2 - v + 10) % 10, 2);
        idle(4);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule